// File: doc/BRIEF.md
# Cache Identification Register Bank

This block is a small coprocessor-style register bank that tells software the cache geometry of the core. Each request carries a read/write flag, three opcode fields (`op1`, `crm`, `op2`) and 32-bit write data. Every accepted request produces one registered response a cycle later, with read data and an error flag.

Reading a cache-size word is indirect. Software first writes a 4-bit selection register, then reads the size word that the selection points at, from a table of sixteen read-only entries. The bank also holds a fixed cache-level descriptor and a fixed cache-type word.

Some encodings are reserved and read as zero rather than faulting. A legacy-architecture input disables the size/level group and the selection write. Every encoding that is not decoded is flagged as an illegal access.

Top module: `cid_regbank`

## Requirements
- R1: After reset the selection register holds 0 and `rsp_valid` and `rsp_err` are low.
- R2: A write with op1=2, crm=0, op2=0 (legacy input low) stores bits [3:0] of `req_wdata` into the selection register and discards the upper bits. Its response carries zero data and no error.
- R3: A read with op1=1, crm=0, op2=0 returns the size word indexed by the current selection value. Entry 0 is 0xE007E01A, entry 1 is 0x2007E01A, entry 2 is 0xF0000000 and entries 3 to 15 are zero.
- R4: A read with op1=1, crm=0, op2=1 returns the cache-level descriptor 0x0A000003.
- R5: A read with op1=1, crm=0, op2=7 returns zero without error. Any other op2 value, or a nonzero crm, in the op1=1 group is illegal.
- R6: A read with op1=2, crm=0, op2=0 returns the selection value zero-extended to 32 bits. A nonzero crm or op2 with op1=2 is illegal.
- R7: While `legacy_arch` is high, a read in the op1=1 group with crm=0 returns zero without error, and the selection write is illegal and leaves the selection unchanged.
- R8: A read with op1=0, crm=0, op2=1 returns the cache-type word 0x82048004.
- R9: An illegal access gives a response with `rsp_err` high for exactly that one response cycle and zero data, and it changes no state. All writes other than the R2 encoding, and all reads not listed in R3 to R8, are illegal.
- R10: `req_ready` is always high. `rsp_valid` is high exactly in the cycle after each cycle in which `req_valid` is high. A read issued in the cycle right after a selection write sees the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_op1 | input | 3 | Opcode field 1 |
| req_crm | input | 4 | Secondary register field |
| req_op2 | input | 3 | Opcode field 2 |
| req_wdata | input | 32 | Write data |
| legacy_arch | input | 1 | High selects the older architecture level |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | 32 | Read data (zero for writes and errors) |
| rsp_err | output | 1 | Illegal access flag |

## Verification
The in-RTL assertions check on every cycle:
- the one-cycle request-to-response relation;
- that an error response carries zero data and leaves the selection register untouched;
- that a legal selection write lands its low four bits;
- that legacy-mode writes never change the selection.

The values behind each encoding can only be shown by the bench's scenarios. These include the size-table contents at several selection values, the reserved op2=7 read, the legacy zero reads, and back-to-back write-then-read ordering. The bench compares each of them against an independent model through a scoreboard.

// File: rtl/cid_pkg.sv
package cid_pkg;

    localparam int DATA_W = 32;
    localparam int OP_W   = 3;
    localparam int CRM_W  = 4;

    localparam logic [DATA_W-1:0] LEVEL_WORD = (32'd1 << 27) | (32'd2 << 24) | 32'd3;
    localparam logic [DATA_W-1:0] TYPE_WORD  = 32'h8204_8004;

    typedef enum logic [2:0] {
        ACC_ILLEGAL,
        ACC_SEL_WR,
        ACC_RD_SIZE,
        ACC_RD_LEVEL,
        ACC_RD_ZERO,
        ACC_RD_SEL,
        ACC_RD_TYPE
    } acc_kind_e;

    typedef struct packed {
        logic             write;
        logic [OP_W-1:0]  op1;
        logic [CRM_W-1:0] crm;
        logic [OP_W-1:0]  op2;
    } acc_req_t;

    typedef struct packed {
        logic              valid;
        logic              err;
        logic [DATA_W-1:0] data;
    } acc_rsp_t;

    function automatic logic [DATA_W-1:0] size_reset(input int idx);
        case (idx)
            0:       return 32'hE007_E01A;
            1:       return 32'h2007_E01A;
            2:       return 32'hF000_0000;
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/cid_decode.sv
module cid_decode
    import cid_pkg::*;
(
    input  acc_req_t  req,
    input  logic      legacy,
    output acc_kind_e kind
);

    always_comb begin
        kind = ACC_ILLEGAL;
        if (req.write) begin
            if (req.op1 == 3'd2 && req.crm == '0 && req.op2 == 3'd0 && !legacy)
                kind = ACC_SEL_WR;
        end else begin
            case (req.op1)
                3'd0: if (req.crm == '0 && req.op2 == 3'd1) kind = ACC_RD_TYPE;
                3'd1: begin
                    if (req.crm == '0) begin
                        if (legacy) kind = ACC_RD_ZERO;
                        else begin
                            case (req.op2)
                                3'd0:    kind = ACC_RD_SIZE;
                                3'd1:    kind = ACC_RD_LEVEL;
                                3'd7:    kind = ACC_RD_ZERO;
                                default: kind = ACC_ILLEGAL;
                            endcase
                        end
                    end
                end
                3'd2: if (req.crm == '0 && req.op2 == 3'd0) kind = ACC_RD_SEL;
                default: kind = ACC_ILLEGAL;
            endcase
        end
    end

endmodule

// File: rtl/cid_size_table.sv
module cid_size_table
    import cid_pkg::*;
#(
    parameter int SEL_W = 4
) (
    input  logic [SEL_W-1:0]  idx,
    output logic [DATA_W-1:0] word
);

    localparam int N_ENT = 1 << SEL_W;

    logic [DATA_W-1:0] entries [N_ENT];

    for (genvar g = 0; g < N_ENT; g++) begin : g_ent
        assign entries[g] = size_reset(g);
    end

    assign word = entries[idx];

endmodule

// File: rtl/cid_regbank.sv
module cid_regbank
    import cid_pkg::*;
#(
    parameter int SEL_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [OP_W-1:0]   req_op1,
    input  logic [CRM_W-1:0]  req_crm,
    input  logic [OP_W-1:0]   req_op2,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              legacy_arch,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err
);

    acc_req_t          req;
    acc_kind_e         kind;
    logic [SEL_W-1:0]  sel_q;
    logic [DATA_W-1:0] size_word;
    logic [DATA_W-1:0] rd_mux;
    acc_rsp_t          rsp_q;
    logic              accept;

    assign req = '{write: req_write, op1: req_op1, crm: req_crm, op2: req_op2};
    assign req_ready = 1'b1;
    assign accept = req_valid && req_ready;

    cid_decode u_dec (
        .req    (req),
        .legacy (legacy_arch),
        .kind   (kind)
    );

    cid_size_table #(.SEL_W(SEL_W)) u_tab (
        .idx  (sel_q),
        .word (size_word)
    );

    always_comb begin
        case (kind)
            ACC_RD_SIZE:  rd_mux = size_word;
            ACC_RD_LEVEL: rd_mux = LEVEL_WORD;
            ACC_RD_TYPE:  rd_mux = TYPE_WORD;
            ACC_RD_SEL:   rd_mux = DATA_W'(sel_q);
            default:      rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
            rsp_q <= '0;
        end else begin
            if (accept && kind == ACC_SEL_WR)
                sel_q <= req_wdata[SEL_W-1:0];
            rsp_q.valid <= accept;
            rsp_q.err   <= accept && kind == ACC_ILLEGAL;
            rsp_q.data  <= accept ? rd_mux : '0;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_err   = rsp_q.err;
    assign rsp_rdata = rsp_q.data;

    a_r10_rsp_follows_req: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    a_r10_no_spurious_rsp: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    a_r9_err_zero_data: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> (rsp_valid && rsp_rdata == '0));

    a_r9_err_keeps_sel: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> $stable(sel_q));

    a_r2_sel_write: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && !legacy_arch && req_op1 == 3'd2 && req_crm == '0
         && req_op2 == 3'd0) |=> sel_q == $past(req_wdata[SEL_W-1:0]));

    a_r7_legacy_no_write: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && legacy_arch) |=> $stable(sel_q));

endmodule

// File: tb/cid_regbank_tb.sv
module cid_regbank_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [2:0]  req_op1 = '0;
    logic [3:0]  req_crm = '0;
    logic [2:0]  req_op2 = '0;
    logic [31:0] req_wdata = '0;
    logic        legacy_arch = 1'b0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        rsp_err;

    int checks = 0;
    int fails  = 0;
    logic [3:0] model_sel = '0;

    logic [31:0] q_data[$];
    logic        q_err[$];
    string       q_tag[$];

    always #5 clk = ~clk;

    cid_regbank dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_op1(req_op1), .req_crm(req_crm),
        .req_op2(req_op2), .req_wdata(req_wdata), .legacy_arch(legacy_arch),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
    );

    function automatic logic [31:0] size_val(input logic [3:0] i);
        if (i == 4'd0) return 32'hE007E01A;
        if (i == 4'd1) return 32'h2007E01A;
        if (i == 4'd2) return 32'hF0000000;
        return 32'h0;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Driver: issue one request, push the expected response
    task automatic issue(input string tag, input logic wr, input logic [2:0] o1,
                         input logic [3:0] cm, input logic [2:0] o2,
                         input logic [31:0] wd, input logic leg);
        logic [31:0] ed;
        logic        ee;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_op1 = o1; req_crm = cm;
        req_op2 = o2; req_wdata = wd; legacy_arch = leg;
        ed = '0; ee = 1'b1;
        if (wr) begin
            if (o1 == 3'd2 && cm == 4'd0 && o2 == 3'd0 && !leg) begin
                ee = 1'b0; model_sel = wd[3:0];
            end
        end else if (o1 == 3'd0 && cm == 4'd0 && o2 == 3'd1) begin
            ee = 1'b0; ed = 32'h82048004;
        end else if (o1 == 3'd1 && cm == 4'd0) begin
            if (leg) ee = 1'b0;
            else if (o2 == 3'd0) begin ee = 1'b0; ed = size_val(model_sel); end
            else if (o2 == 3'd1) begin ee = 1'b0; ed = 32'h0A000003; end
            else if (o2 == 3'd7) ee = 1'b0;
        end else if (o1 == 3'd2 && cm == 4'd0 && o2 == 3'd0) begin
            ee = 1'b0; ed = {28'h0, model_sel};
        end
        q_data.push_back(ed);
        q_err.push_back(ee);
        q_tag.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0; req_write = 1'b0;
        end
    endtask

    // Monitor: pop and compare
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (q_data.size() == 0) begin
                checks++; fails++;
                $display("FAIL R10: actual unexpected response expected none");
            end else begin
                automatic string t = q_tag.pop_front();
                check({t, " data"}, rsp_rdata, q_data.pop_front());
                check({t, " err"}, {31'h0, rsp_err}, {31'h0, q_err.pop_front()});
            end
        end
    end

    initial begin
        #2000000;
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 rsp_valid after reset", {31'h0, rsp_valid}, 32'h0);
        check("R1 rsp_err after reset", {31'h0, rsp_err}, 32'h0);
        check("R10 req_ready", {31'h0, req_ready}, 32'h1);
        issue("R1 R6 sel reset read", 0, 2, 0, 0, 0, 0);
        issue("R8 type read", 0, 0, 0, 1, 0, 0);
        issue("R4 level read", 0, 1, 0, 1, 0, 0);
        issue("R3 size entry0", 0, 1, 0, 0, 0, 0);
        issue("R2 sel write upper bits", 1, 2, 0, 0, 32'hFFFF_FFF1, 0);
        issue("R10 R6 read after write", 0, 2, 0, 0, 0, 0);
        issue("R3 size entry1", 0, 1, 0, 0, 0, 0);
        issue("R2 sel write 2", 1, 2, 0, 0, 32'h2, 0);
        issue("R3 size entry2", 0, 1, 0, 0, 0, 0);
        issue("R2 sel write 9", 1, 2, 0, 0, 32'hA5A5_A5A9, 0);
        issue("R3 size entry9", 0, 1, 0, 0, 0, 0);
        issue("R2 sel write 15", 1, 2, 0, 0, 32'hF, 0);
        issue("R3 size entry15", 0, 1, 0, 0, 0, 0);
        issue("R5 reserved op2=7", 0, 1, 0, 7, 0, 0);
        issue("R5 illegal op2=3", 0, 1, 0, 3, 0, 0);
        issue("R5 illegal crm=1", 0, 1, 1, 0, 0, 0);
        issue("R6 illegal op2=1", 0, 2, 0, 1, 0, 0);
        issue("R6 illegal crm=2", 0, 2, 2, 0, 0, 0);
        issue("R9 illegal write op1=1", 1, 1, 0, 0, 32'h3, 0);
        issue("R9 illegal write crm=1", 1, 2, 1, 0, 32'h4, 0);
        issue("R9 sel unchanged", 0, 2, 0, 0, 0, 0);
        issue("R9 illegal op1=3", 0, 3, 0, 0, 0, 0);
        issue("R9 type write illegal", 1, 0, 0, 1, 32'h1, 0);
        idle(1);
        issue("R7 legacy size read", 0, 1, 0, 0, 0, 1);
        issue("R7 legacy level read", 0, 1, 0, 1, 0, 1);
        issue("R7 legacy sel write", 1, 2, 0, 0, 32'h5, 1);
        issue("R7 legacy sel read", 0, 2, 0, 0, 0, 1);
        issue("R7 sel unchanged after legacy", 0, 2, 0, 0, 0, 0);
        issue("R9 legal after error", 0, 1, 0, 1, 0, 0);
        idle(3);
        check("R10 idle no response", {31'h0, rsp_valid}, 32'h0);
        check("R10 all responses seen", q_data.size(), 32'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule